// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Prescalers

This block produces two independent pulse-width modulated outputs from the module clock. Each channel is set by one 32-bit word that packs two 16-bit cycle counts. The upper half is the number of prescaled ticks the output stays high. The lower half is the number of ticks it then stays low. A shared control word gives each channel a 7-bit divider field, so each channel ticks at the module clock divided by (field + 1). The control word also holds two enables per channel: a clock enable and a run enable.

Software reaches the block through a simple word bus. It has a byte address, a write strobe, write data and combinational read data. Byte address 0 selects channel A, byte address 4 selects channel B and byte address 8 selects the control word. The two low address bits are ignored. A channel word written while the channel runs is held in a staging copy and takes effect only at the next period boundary, so a period is never cut short or mixed. While a channel is not fully enabled, its output is low and its counters stay at their start point.

Top module: `duo_pwm`

## Requirements
- R1: After reset, all three words read zero and both outputs are low.
- R2: A channel word reads back exactly as written: byte address 0 for channel A, byte address 4 for channel B.
- R3: The control word at byte address 8 keeps only the bits set in mask 0x00FFFF03. All other bits read zero and ignore writes. Byte address 12 reads zero.
- R4: A running channel outputs high for H×(D+1) module cycles, then low for L×(D+1) cycles, and repeats. H is bits 31:16 of the channel word and L is bits 15:0. D is control bits 14:8 for channel A and bits 22:16 for channel B. The high phase starts in the first cycle after the enabling write.
- R5: A channel runs only when both its clock enable and its run enable are set. For channel A these are control bits 15 and 0; for channel B they are bits 23 and 1. Otherwise its output is low. A re-enabled channel restarts at the beginning of its high phase.
- R6: A channel word written while the channel runs leaves the current period unchanged. It applies from the next period boundary.
- R7: H = 0 gives a constant low output. L = 0 with H > 0 gives a constant high output. H = L = 0 gives a constant low output.
- R8: The two channels run at the same time with separate counts and dividers, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
A prescaler or position counter that is off by one shows up as a high or low phase that is one tick too long or too short. This appears within the first period after enabling, so the bench compares every cycle of several periods against a model computed from H, L and D. A staging copy that loads too early would let a mid-period write change the remainder of the current period. The bench therefore writes mid-period and checks the old shape up to the boundary and the new shape after it. Enable decoding faults show up as activity on an output whose enables are incomplete, or as a restart that does not begin high.

// File: rtl/duo_pwm.sv
module duo_pwm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_a,
  output logic        pwm_b
);
  localparam logic [31:0] CTRL_MASK = 32'h00FF_FF03;

  logic [31:0]      ctrl_q;
  logic [1:0][31:0] cfg_q;
  logic [1:0][31:0] live_q;
  logic [1:0][16:0] pos_q;
  logic [1:0]       act, wrap, pwm;
  logic [1:0]       word;
  logic             unused_lsb;

  assign word       = bus_addr[3:2];
  assign unused_lsb = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else if (bus_we) begin
      case (word)
        2'd0:    cfg_q[0] <= bus_wdata;
        2'd1:    cfg_q[1] <= bus_wdata;
        2'd2:    ctrl_q   <= bus_wdata & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      2'd0:    bus_rdata = cfg_q[0];
      2'd1:    bus_rdata = cfg_q[1];
      2'd2:    bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [6:0]  div, pre;
    logic [16:0] pos, total;
    logic [31:0] live;
    logic        tick;

    assign div    = ctrl_q[8 + 8*c +: 7];
    assign act[c] = ctrl_q[15 + 8*c] & ctrl_q[c];
    assign total  = {1'b0, live[31:16]} + {1'b0, live[15:0]};
    assign tick   = (pre == div);
    assign wrap[c] = tick && ((total == 17'd0) || (pos == total - 17'd1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pre  <= '0;
        pos  <= '0;
        live <= '0;
      end else if (!act[c]) begin
        pre  <= '0;
        pos  <= '0;
        live <= cfg_q[c];
      end else begin
        pre <= tick ? 7'd0 : pre + 7'd1;
        if (wrap[c]) begin
          pos  <= '0;
          live <= cfg_q[c];
        end else if (tick) begin
          pos <= pos + 17'd1;
        end
      end
    end

    assign pwm[c]    = act[c] && (pos < {1'b0, live[31:16]});
    assign pos_q[c]  = pos;
    assign live_q[c] = live;
  end

  assign pwm_a = pwm[0];
  assign pwm_b = pwm[1];
endmodule

// File: rtl/duo_pwm_checker.sv
module duo_pwm_checker (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [31:0]      ctrl_q,
  input logic [1:0]       act,
  input logic [1:0]       wrap,
  input logic [1:0][31:0] live_q,
  input logic [1:0][16:0] pos_q,
  input logic             pwm_a,
  input logic             pwm_b
);
  logic [1:0] outs;
  assign outs = {pwm_b, pwm_a};

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd2) |-> ((bus_rdata & ~32'h00FF_FF03) == 32'd0));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    logic [16:0] tot;
    assign tot = {1'b0, live_q[c][31:16]} + {1'b0, live_q[c][15:0]};

    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_q[15 + 8*c] && ctrl_q[c]) |-> !outs[c]);

    p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act[c] && !wrap[c]) |=> $stable(live_q[c]));

    p_pos_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act[c] && tot != 17'd0) |-> (pos_q[c] < tot));

    p_const_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act[c] && live_q[c][31:16] != 16'd0 && live_q[c][15:0] == 16'd0) |-> outs[c]);
  end
endmodule

bind duo_pwm duo_pwm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ctrl_q(ctrl_q), .act(act), .wrap(wrap), .live_q(live_q), .pos_q(pos_q),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/duo_pwm_test.sv
module duo_pwm_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        pwm_a, pwm_b;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  duo_pwm uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b));

  function automatic bit exp_out(int k, int hi, int lo, int d);
    if (hi + lo == 0) return 0;
    return ((k / (d + 1)) % (hi + lo)) < hi;
  endfunction

  function automatic logic [31:0] en_word(int ch, int d);
    return ch == 0 ? (32'h8000 | (d << 8) | 32'h1) : (32'h80_0000 | (d << 16) | 32'h2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic check_wave(string req, int ch, int hi, int lo, int d, int k0, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, ch == 0 ? pwm_a : pwm_b, exp_out(k0 + i, hi, lo, d));
    end
  endtask

  task automatic run_wave(string req, int ch, int hi, int lo, int d, int n);
    wr(4'd8, 32'd0);
    wr(ch == 0 ? 4'd0 : 4'd4, {hi[15:0], lo[15:0]});
    wr(4'd8, en_word(ch, d));
    check_wave(req, ch, hi, lo, d, 0, n);
  endtask

  task automatic t_reset;
    rd_check("R1", 4'd0, 0);
    rd_check("R1", 4'd4, 0);
    rd_check("R1", 4'd8, 0);
    check("R1", {pwm_b, pwm_a}, 0);
  endtask

  task automatic t_regs;
    wr(4'd0, 32'hDEAD_BEEF);
    rd_check("R2", 4'd0, 32'hDEAD_BEEF);
    wr(4'd4, 32'h1234_5678);
    rd_check("R2", 4'd4, 32'h1234_5678);
    rd_check("R2", 4'd0, 32'hDEAD_BEEF);
    wr(4'd8, 32'hFFFF_FFFF);
    rd_check("R3", 4'd8, 32'h00FF_FF03);
    rd_check("R3", 4'd12, 32'd0);
    wr(4'd8, 32'd0);
    rd_check("R3", 4'd8, 32'd0);
  endtask

  task automatic t_shapes;
    run_wave("R4", 0, 2, 3, 0, 30);
    run_wave("R4", 0, 3, 1, 2, 40);
    run_wave("R4", 1, 1, 4, 3, 60);
    run_wave("R4", 0, 1, 1, 127, 600);
  endtask

  task automatic t_enables;
    wr(4'd0, {16'd2, 16'd2});
    wr(4'd4, {16'd2, 16'd2});
    wr(4'd8, 32'h0080_8000);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); check("R5 clk-only", {pwm_b, pwm_a}, 0);
    end
    wr(4'd8, 32'h0000_0003);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); check("R5 run-only", {pwm_b, pwm_a}, 0);
    end
    wr(4'd8, en_word(0, 0));
    check_wave("R5", 0, 2, 2, 0, 0, 3);
    wr(4'd8, 32'h0000_8000);
    @(negedge clk); check("R5 off", pwm_a, 0);
    wr(4'd8, en_word(0, 0));
    check_wave("R5 restart", 0, 2, 2, 0, 0, 8);
  endtask

  task automatic t_staging;
    wr(4'd8, 32'd0);
    wr(4'd0, {16'd3, 16'd3});
    wr(4'd8, en_word(0, 0));
    check_wave("R6", 0, 3, 3, 0, 0, 2);
    wr(4'd0, {16'd1, 16'd1});
    check_wave("R6 old", 0, 3, 3, 0, 3, 3);
    check_wave("R6 new", 0, 1, 1, 0, 0, 8);
  endtask

  task automatic t_degenerate;
    run_wave("R7 hi0", 0, 0, 5, 0, 20);
    run_wave("R7 lo0", 0, 4, 0, 0, 20);
    run_wave("R7 zero", 1, 0, 0, 1, 20);
  endtask

  task automatic t_both;
    wr(4'd8, 32'd0);
    wr(4'd0, {16'd2, 16'd3});
    wr(4'd4, {16'd3, 16'd1});
    wr(4'd8, en_word(0, 1) | en_word(1, 0));
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check("R8 A", pwm_a, exp_out(i, 2, 3, 1));
      check("R8 B", pwm_b, exp_out(i, 3, 1, 0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regs();
    t_shapes();
    t_enables();
    t_staging();
    t_degenerate();
    t_both();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule